// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block decides when a volatile SRAM array is copied into its nonvolatile shadow (STORE) and when the shadow is copied back (RECALL). Requests come from four places: a shared active-low request/busy line, a supply-low flag from a power comparator, the return of good supply, and single-cycle software strobes produced by a separate address-sequence detector. Two more software strobes turn automatic power-fail storing off and on.

Each transfer runs as two timed phases. STORE is an erase followed by a program, and RECALL is an array clear followed by a load. Every phase length is a parameter counted in clock cycles. While STORE is running, the block pulls the shared line low through an open-drain style enable. For the whole of any transfer it raises an inhibit for SRAM reads and writes. It also keeps a flag that records whether any write has completed since the last transfer. Hardware-line and power-fail stores are skipped when that flag is clear. A software store always runs.

Requests are sampled on the rising clock edge. The line is expected to be synchronous to the clock. The analog supply switch, the storage capacitor and the memory cells lie outside the block; they are represented only by the phase code and the timing.

Top module: `nv_xfer_seq`

## Requirements
- R1: Reset (rst_n low) gives phase 0 (idle), busy_pull 0, sram_inhibit 0 and dirty 0. It also enables auto-store and arms a pending recall. The first clock edge after reset with pwr_low low enters the clear phase.
- R2: The phase code is 0 idle, 1 grace, 2 erase, 3 program, 4 clear, 5 load, 6 hold. A STORE spends exactly P_ERASE cycles in erase, then P_PROG cycles in program, then enters hold. busy_pull is 1 in erase and program and 0 in every other phase. A RECALL spends P_CLEAR cycles in clear, then P_LOAD cycles in load, then returns to idle.
- R3: sram_inhibit is 1 in erase, program, clear, load and hold, and 0 in idle and grace. A wr_done pulse that arrives while sram_inhibit is 1 does not set dirty.
- R4: A store requested by the hardware line or by power-fail does not run while dirty is 0. In that case the block goes back to idle and busy_pull stays 0.
- R5: A sw_store strobe taken in idle starts erase on the next edge, whether dirty is 0 or 1.
- R6: A falling edge of line_n seen in idle enters grace for P_GRACE cycles. A wr_done that arrives in any grace cycle except the last one counts toward the dirty decision made at the end of grace. wr_block is 1 whenever line_n is low, during grace, and while sram_inhibit is 1.
- R7: After program, the block stays in hold while line_n is low. It moves to idle on the edge after line_n is seen high.
- R8: A rising edge of pwr_low starts a store when auto-store is enabled (subject to R4). While pwr_low is high a recall is latched, and that recall starts on the first edge in idle with pwr_low low.
- R9: dirty is set by wr_done when sram_inhibit is 0. It is cleared on the edge that starts any STORE or RECALL.
- R10: When several requests reach idle in the same cycle, the order is power-fail store, then power-return recall, then hardware line, then sw_store, then sw_recall.
- R11: as_off disables auto-store, so a pwr_low rise starts no store. as_on enables it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_n | input | 1 | Level of the shared active-low request/busy line |
| pwr_low | input | 1 | Supply below switch threshold |
| sw_store | input | 1 | Software store strobe |
| sw_recall | input | 1 | Software recall strobe |
| as_off | input | 1 | Auto-store disable strobe |
| as_on | input | 1 | Auto-store enable strobe |
| wr_done | input | 1 | An SRAM write completed this cycle |
| busy_pull | output | 1 | Pull the shared line low (open-drain enable) |
| sram_inhibit | output | 1 | Block SRAM reads and writes |
| wr_block | output | 1 | Block newly requested SRAM writes |
| dirty | output | 1 | A write has completed since the last transfer |
| phase | output | 3 | Current phase code |

## Verification
A request that is sampled on an edge shows up in the phase code right after that same edge. Each timed phase then holds for exactly its parameter count, and hold leaves on the edge after the line is seen high. The bench drives inputs just after an edge and samples one nanosecond later. It walks each phase cycle by cycle against lengths set in its own parameters. A sweep moves one write pulse across every grace cycle and predicts arithmetically whether the store runs: it runs only if the pulse lands before the final grace edge.

// File: rtl/nvx_pkg.sv
package nvx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_GRACE = 3'd1,
    PH_ERASE = 3'd2,
    PH_PROG  = 3'd3,
    PH_CLEAR = 3'd4,
    PH_LOAD  = 3'd5,
    PH_HOLD  = 3'd6
  } phase_e;

  typedef enum logic [2:0] {
    GO_NONE       = 3'd0,
    GO_PF_STORE   = 3'd1,
    GO_PWR_RECALL = 3'd2,
    GO_HW_GRACE   = 3'd3,
    GO_SW_STORE   = 3'd4,
    GO_SW_RECALL  = 3'd5
  } go_e;

  // Cycles spent in a phase; untimed phases report 1 so that minus one is 0.
  function automatic int unsigned phase_cycles(phase_e p, int unsigned g,
                                               int unsigned e, int unsigned pr,
                                               int unsigned c, int unsigned l);
    case (p)
      PH_GRACE: return g;
      PH_ERASE: return e;
      PH_PROG:  return pr;
      PH_CLEAR: return c;
      PH_LOAD:  return l;
      default:  return 1;
    endcase
  endfunction

  function automatic int unsigned max5(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d,
                                       int unsigned e);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

  // Fixed priority among qualified requests seen in idle.
  function automatic go_e pick_go(logic pf_ok, logic pwr_rec, logic hw_fall,
                                  logic sws, logic swr);
    if (pf_ok)        return GO_PF_STORE;
    else if (pwr_rec) return GO_PWR_RECALL;
    else if (hw_fall) return GO_HW_GRACE;
    else if (sws)     return GO_SW_STORE;
    else if (swr)     return GO_SW_RECALL;
    else              return GO_NONE;
  endfunction

endpackage

// File: rtl/nvx_req_arb.sv
module nvx_req_arb
  import nvx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_low,
  input  logic line_n,
  input  logic sw_store,
  input  logic sw_recall,
  input  logic as_off,
  input  logic as_on,
  input  logic dirty,
  input  logic in_idle,
  input  logic in_grace,
  output go_e  go,
  output logic auto_en,
  output logic recall_pend
);

  logic prev_pwr, prev_line;
  logic pf_rise, line_fall, pf_ok, pwr_rec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_pwr  <= 1'b0;
      prev_line <= 1'b1;
    end else begin
      prev_pwr  <= pwr_low;
      prev_line <= line_n;
    end
  end

  assign pf_rise   = pwr_low & ~prev_pwr;
  assign line_fall = prev_line & ~line_n;
  assign pf_ok     = pf_rise & auto_en & dirty;
  assign pwr_rec   = recall_pend & ~pwr_low;

  always_comb begin
    go = GO_NONE;
    if (in_idle)
      go = pick_go(pf_ok, pwr_rec, line_fall, sw_store, sw_recall);
    else if (in_grace && pf_ok)
      go = GO_PF_STORE;
  end

  // auto-store enable: on after reset, software strobes toggle it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     auto_en <= 1'b1;
    else if (as_on)  auto_en <= 1'b1;
    else if (as_off) auto_en <= 1'b0;
  end

  // recall latched while the supply is low; consumed when it starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  recall_pend <= 1'b1;
    else if (pwr_low)            recall_pend <= 1'b1;
    else if (go == GO_PWR_RECALL) recall_pend <= 1'b0;
  end

  p_recall_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_low |=> recall_pend);
  p_auto_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (as_off && !as_on) |=> !auto_en);

endmodule

// File: rtl/nvx_phase_timer.sv
module nvx_phase_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/nvx_dirty_track.sv
module nvx_dirty_track (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_done,
  input  logic inhibit,
  input  logic xfer_start,
  output logic dirty_q
);

  logic set_ok;
  assign set_ok = wr_done & ~inhibit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dirty_q <= 1'b0;
    else if (xfer_start) dirty_q <= 1'b0;
    else if (set_ok)     dirty_q <= 1'b1;
  end

  p_clear_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !dirty_q);
  p_no_set_inhibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !xfer_start) |=> dirty_q == $past(dirty_q));

endmodule

// File: rtl/nv_xfer_seq.sv
module nv_xfer_seq
  import nvx_pkg::*;
#(
  parameter int unsigned P_GRACE = 3,
  parameter int unsigned P_ERASE = 4,
  parameter int unsigned P_PROG  = 5,
  parameter int unsigned P_CLEAR = 2,
  parameter int unsigned P_LOAD  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_n,
  input  logic       pwr_low,
  input  logic       sw_store,
  input  logic       sw_recall,
  input  logic       as_off,
  input  logic       as_on,
  input  logic       wr_done,
  output logic       busy_pull,
  output logic       sram_inhibit,
  output logic       wr_block,
  output logic       dirty,
  output logic [2:0] phase
);

  localparam int unsigned MAXL = max5(P_GRACE, P_ERASE, P_PROG, P_CLEAR, P_LOAD);
  localparam int unsigned CW   = $clog2(MAXL + 1);

  phase_e        phase_q, phase_n;
  go_e           go;
  logic          tmr_done, tmr_load;
  logic [CW-1:0] tmr_val;
  logic          auto_en, recall_pend;
  logic          in_idle, in_grace;

  // named internal events
  logic store_go, recall_go, grace_go, grace_skip, xfer_start;

  assign in_idle  = (phase_q == PH_IDLE);
  assign in_grace = (phase_q == PH_GRACE);

  nvx_req_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_low    (pwr_low),
    .line_n     (line_n),
    .sw_store   (sw_store),
    .sw_recall  (sw_recall),
    .as_off     (as_off),
    .as_on      (as_on),
    .dirty      (dirty),
    .in_idle    (in_idle),
    .in_grace   (in_grace),
    .go         (go),
    .auto_en    (auto_en),
    .recall_pend(recall_pend)
  );

  always_comb begin
    phase_n    = phase_q;
    store_go   = 1'b0;
    recall_go  = 1'b0;
    grace_go   = 1'b0;
    grace_skip = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        case (go)
          GO_PF_STORE, GO_SW_STORE: begin
            phase_n  = PH_ERASE;
            store_go = 1'b1;
          end
          GO_PWR_RECALL, GO_SW_RECALL: begin
            phase_n   = PH_CLEAR;
            recall_go = 1'b1;
          end
          GO_HW_GRACE: begin
            phase_n  = PH_GRACE;
            grace_go = 1'b1;
          end
          default: phase_n = PH_IDLE;
        endcase
      end
      PH_GRACE: begin
        if (go == GO_PF_STORE) begin
          phase_n  = PH_ERASE;
          store_go = 1'b1;
        end else if (tmr_done) begin
          if (dirty) begin
            phase_n  = PH_ERASE;
            store_go = 1'b1;
          end else begin
            phase_n    = PH_IDLE;
            grace_skip = 1'b1;
          end
        end
      end
      PH_ERASE: if (tmr_done) phase_n = PH_PROG;
      PH_PROG:  if (tmr_done) phase_n = PH_HOLD;
      PH_CLEAR: if (tmr_done) phase_n = PH_LOAD;
      PH_LOAD:  if (tmr_done) phase_n = PH_IDLE;
      PH_HOLD:  if (line_n)   phase_n = PH_IDLE;
      default:  phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_n;
  end

  assign tmr_load = (phase_n != phase_q);
  assign tmr_val  = CW'(phase_cycles(phase_n, P_GRACE, P_ERASE, P_PROG,
                                     P_CLEAR, P_LOAD) - 1);

  nvx_phase_timer #(.CW(CW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .done    (tmr_done)
  );

  assign xfer_start = store_go | recall_go;

  nvx_dirty_track u_dirty (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_done   (wr_done),
    .inhibit   (sram_inhibit),
    .xfer_start(xfer_start),
    .dirty_q   (dirty)
  );

  assign busy_pull    = (phase_q == PH_ERASE) | (phase_q == PH_PROG);
  assign sram_inhibit = busy_pull | (phase_q == PH_CLEAR) |
                        (phase_q == PH_LOAD) | (phase_q == PH_HOLD);
  assign wr_block     = sram_inhibit | ~line_n | in_grace;
  assign phase        = phase_q;

  p_busy_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_pull) |-> ($past(phase_q) == PH_IDLE || $past(phase_q) == PH_GRACE));
  p_prog_after_erase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PROG && $past(phase_q) != PH_PROG) |-> $past(phase_q) == PH_ERASE);
  p_hold_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HOLD && line_n) |=> phase_q == PH_IDLE);
  p_hold_stay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HOLD && !line_n) |=> phase_q == PH_HOLD);
  p_grace_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grace_skip |=> (phase_q == PH_IDLE && !busy_pull));
  p_one_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_go, recall_go, grace_go, grace_skip}));

endmodule

// File: tb/nv_xfer_seq_bench.sv
module nv_xfer_seq_bench;

  localparam int G = 3, E = 4, PR = 5, C = 2, L = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_n = 1'b1, pwr_low = 1'b0, sw_store = 1'b0, sw_recall = 1'b0;
  logic as_off = 1'b0, as_on = 1'b0, wr_done = 1'b0;
  logic busy_pull, sram_inhibit, wr_block, dirty, line_n;
  logic [2:0] phase;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  assign line_n = ext_n & ~busy_pull;  // open-drain wired line

  nv_xfer_seq #(.P_GRACE(G), .P_ERASE(E), .P_PROG(PR), .P_CLEAR(C), .P_LOAD(L))
  u_nv_xfer_seq (
    .clk(clk), .rst_n(rst_n), .line_n(line_n), .pwr_low(pwr_low),
    .sw_store(sw_store), .sw_recall(sw_recall), .as_off(as_off), .as_on(as_on),
    .wr_done(wr_done), .busy_pull(busy_pull), .sram_inhibit(sram_inhibit),
    .wr_block(wr_block), .dirty(dirty), .phase(phase)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // inputs change 1 ns after an edge; outputs are read 2 ns after it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic run(int ph, int n, string tag);
    for (int i = 0; i < n; i++) begin
      #1;
      chk({tag, " phase"}, phase, ph);
      chk({tag, " busy"}, busy_pull, (ph == 2 || ph == 3) ? 1 : 0);
      chk({tag, " inhibit"}, sram_inhibit, (ph >= 2) ? 1 : 0);
      #0 step();
    end
  endtask

  task automatic pulse_write();
    wr_done = 1'b1; step(); wr_done = 1'b0;
  endtask

  task automatic do_store_tail(int hold_cycles, string tag);
    run(2, E, {tag, " erase"});
    run(3, PR, {tag, " prog"});
    run(6, hold_cycles, {tag, " hold"});
  endtask

  initial begin
    // R1 reset state
    #3;
    chk("R1 reset phase", phase, 0);
    chk("R1 reset busy", busy_pull, 0);
    chk("R1 reset inhibit", sram_inhibit, 0);
    chk("R1 reset dirty", dirty, 0);
    step(); step();
    rst_n = 1'b1;
    step();
    run(4, C, "R1 power-up clear");
    run(5, L, "R1 power-up load");
    run(0, 1, "R1 idle");

    // R5 software store without a prior write
    sw_store = 1'b1; step(); sw_store = 1'b0;
    do_store_tail(1, "R5");
    run(0, 1, "R5 idle");

    // R4/R6 hardware request with clean array is skipped
    ext_n = 1'b0; step();
    #1 chk("R6 wr_block grace", wr_block, 1);
    run(1, G, "R6 grace");
    run(0, 2, "R4 skip idle");
    #1 chk("R6 wr_block while low", wr_block, 1);
    ext_n = 1'b1; step();
    #1 chk("R6 wr_block released", wr_block, 0);

    // R9 write sets dirty; R6 sweep of write position inside grace
    for (int j = 0; j < G; j++) begin
      ext_n = 1'b0; step();
      for (int c = 0; c < G; c++) begin
        wr_done = (c == j);
        #1 chk("R6 sweep grace", phase, 1);
        step();
        wr_done = 1'b0;
      end
      if (j < G - 1) begin
        #1 chk("R9 dirty cleared at store", dirty, 0);
        do_store_tail(2, "R6 sweep");
        ext_n = 1'b1; step();
        run(0, 1, "R7 hold exit");
      end else begin
        run(0, 1, "R6 late write skip");
        chk("R9 late write dirty", dirty, 1);
        ext_n = 1'b1; step();
        sw_recall = 1'b1; step(); sw_recall = 1'b0;
        wr_done = 1'b1;
        run(4, C, "R3 recall clear");
        wr_done = 1'b0;
        run(5, L, "R3 recall load");
        chk("R3 write ignored while inhibited", dirty, 0);
      end
    end

    // R7 hold waits for line high; R9 dirty set
    pulse_write();
    #1 chk("R9 dirty set", dirty, 1);
    ext_n = 1'b0; step();
    run(1, G, "R7 grace");
    do_store_tail(4, "R7");
    ext_n = 1'b1; step();
    run(0, 1, "R7 idle");

    // R8 power-fail store and recall on supply return
    pulse_write();
    pwr_low = 1'b1; step();
    do_store_tail(1, "R8 pf");
    run(0, 3, "R8 idle while low");
    pwr_low = 1'b0; step();
    run(4, C, "R8 recall clear");
    run(5, L, "R8 recall load");

    // R4 power-fail with clean array: no store
    pwr_low = 1'b1; step();
    run(0, 2, "R4 pf skip");
    pwr_low = 1'b0; step();
    run(4, C, "R4 recall after skip");
    run(5, L, "R4 recall load");

    // R11 auto-store off then on
    pulse_write();
    as_off = 1'b1; step(); as_off = 1'b0;
    pwr_low = 1'b1; step();
    run(0, 2, "R11 auto off");
    chk("R11 dirty kept", dirty, 1);
    pwr_low = 1'b0; step();
    run(4, C, "R11 recall");
    run(5, L, "R11 load");
    as_on = 1'b1; step(); as_on = 1'b0;
    pulse_write();
    pwr_low = 1'b1; step();
    run(2, 1, "R11 auto on store");
    run(2, E - 1, "R11 erase");
    run(3, PR, "R11 prog");
    run(6, 1, "R11 hold");
    pwr_low = 1'b0; step();
    run(4, C, "R11 recall");
    run(5, L, "R11 load");

    // R10 priority: all requests at once, power-fail store wins
    pulse_write();
    pwr_low = 1'b1; ext_n = 1'b0; sw_store = 1'b1; sw_recall = 1'b1;
    step();
    sw_store = 1'b0; sw_recall = 1'b0;
    do_store_tail(2, "R10 pf first");
    ext_n = 1'b1; step();
    run(0, 1, "R10 idle");
    sw_store = 1'b1; sw_recall = 1'b1; step();
    sw_store = 1'b0; sw_recall = 1'b0;
    do_store_tail(1, "R10 sw store over recall");
    pwr_low = 1'b0; ext_n = 1'b0; step();
    run(4, C, "R10 power recall over line");
    run(5, L, "R10 load");
    ext_n = 1'b1; step();
    sw_recall = 1'b1; step(); sw_recall = 1'b0;
    run(4, C, "R10 sw recall alone");
    run(5, L, "R10 load");
    run(0, 1, "R10 final idle");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule